// File: doc/BRIEF.md
# Serial Flash Dummy-Cycle Configuration Sequencer

This block programs the number of wait clocks that a serial NOR flash inserts before it returns data on a fast read. A host pulses `start` with a read-command class and a requested wait-clock count. The block turns that pair into a 2-bit setting code. It then reads the flash configuration register over a single-bit SPI link that it drives itself.

If the setting field already holds the code, the block stops there. If not, it rewrites the register and keeps every other configuration bit. The rewrite reads the status register, enables writes, and sends the status byte and the new configuration byte in one write command. After the write, the block polls the busy flag and then reads the register back to confirm the change. One `done` pulse ends every request. On failure `err` is high in the same cycle. On success `applied_cnt` takes the new wait-clock count.

The block is meant to run once at boot, or whenever the read mode changes, before a memory-read engine takes over the same SPI pins.

Top module: `flash_dummy_cfg`

## Requirements
- R1: Class codes are 0 for a plain read, 1 for fast read with single, dual or quad data output, 2 for dual address and data, and 3 for quad address and data. For class 1, counts 6, 8 and 10 map to setting codes 1, 0 and 3. For class 2, counts 4, 6, 8 and 10 map to 0, 1, 2 and 3. For class 3, counts 4, 6, 8 and 10 map to 1, 0, 2 and 3.
- R2: Class 0 always uses setting code 0 and ignores the requested count. On success, `applied_cnt` becomes 0.
- R3: A class from 4 to 7, or a count that R1 does not list for the class, ends the request with `done` and `err` high together. No chip-select activity takes place.
- R4: The first command of a valid request is 0x15 followed by one response byte. If response bits [7:6] equal the setting code, the request ends with no further command.
- R5: Otherwise three commands follow in this order. First, 0x05 with one response byte. Second, 0x06 alone. Third, 0x01 followed by the status byte just read and then the configuration byte with only bits [7:6] replaced by the code.
- R6: After the write, the block sends 0x05 again until status bit 0 reads 0. If POLL_MAX reads in a row return 1, the request ends with an error.
- R7: Once the flash is ready, the block sends 0x15 again. If bits [7:6] differ from the code, the request ends with an error.
- R8: `applied_cnt` resets to 0. It changes only in the cycle where `done` is high and `err` is low, and then it takes the requested count.
- R9: The SPI link runs in mode 0 with the most significant bit first. The clock is low whenever chip select is high. Chip select goes high between commands.
- R10: `done` and `err` are one-cycle pulses, and `err` is never high without `done`. A `start` pulse while `busy` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, sampled while idle |
| op_class | input | 3 | Read-command class (R1 encoding) |
| dummy_cnt | input | CNT_W | Requested wait-clock count |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Failure flag, valid with done |
| applied_cnt | output | CNT_W | Count applied by the last successful request |
| spi_sclk | output | 1 | SPI clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The bench drives the block against a behavioural flash that decodes the SPI bit stream and can be set up with a stuck register or a long busy period. A sweep of class and count pairs catches a mapping table with swapped entries for dual and quad address classes, and also a class 0 request that reports a nonzero count. Directed cases go after the following faults:
- A sequencer that writes when the field already matches.
- A write that disturbs the low six configuration bits or sends the status byte in the wrong slot.
- A poll limit that is off by one.
- Missing read-back verification.
- `applied_cnt` moving after an error.
- A second `start` during a request that restarts or corrupts it.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

  localparam logic [7:0] OP_RD_CFG = 8'h15;
  localparam logic [7:0] OP_RD_ST  = 8'h05;
  localparam logic [7:0] OP_WR_EN  = 8'h06;
  localparam logic [7:0] OP_WR_REG = 8'h01;

  localparam logic [2:0] CLS_PLAIN   = 3'd0;
  localparam logic [2:0] CLS_FAST    = 3'd1;
  localparam logic [2:0] CLS_DUAL_IO = 3'd2;
  localparam logic [2:0] CLS_QUAD_IO = 3'd3;

  typedef enum logic [2:0] {
    PH_CFG_RD1,
    PH_ST_RD,
    PH_WEN,
    PH_WRITE,
    PH_POLL,
    PH_CFG_RD2
  } phase_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MAP,
    ST_LOAD,
    ST_SEND,
    ST_WAIT,
    ST_GAP,
    ST_NEXT
  } state_t;

  function automatic logic [7:0] phase_opcode(phase_t p);
    case (p)
      PH_ST_RD, PH_POLL:      phase_opcode = OP_RD_ST;
      PH_WEN:                 phase_opcode = OP_WR_EN;
      PH_WRITE:               phase_opcode = OP_WR_REG;
      default:                phase_opcode = OP_RD_CFG;
    endcase
  endfunction

  function automatic logic [1:0] phase_len(phase_t p);
    case (p)
      PH_WEN:   phase_len = 2'd1;
      PH_WRITE: phase_len = 2'd3;
      default:  phase_len = 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/fdc_code_map.sv
module fdc_code_map #(
  parameter int CNT_W = 4
) (
  input  logic [2:0]       cls,
  input  logic [CNT_W-1:0] cnt,
  output logic             ok,
  output logic [1:0]       code,
  output logic [CNT_W-1:0] eff_cnt
);
  import fdc_pkg::*;

  localparam logic [CNT_W-1:0] C4  = CNT_W'(4);
  localparam logic [CNT_W-1:0] C6  = CNT_W'(6);
  localparam logic [CNT_W-1:0] C8  = CNT_W'(8);
  localparam logic [CNT_W-1:0] C10 = CNT_W'(10);

  always_comb begin
    ok      = 1'b1;
    code    = 2'd0;
    eff_cnt = cnt;
    case (cls)
      CLS_PLAIN: begin
        eff_cnt = '0;
      end
      CLS_FAST: begin
        if (cnt == C6)       code = 2'd1;
        else if (cnt == C8)  code = 2'd0;
        else if (cnt == C10) code = 2'd3;
        else                 ok   = 1'b0;
      end
      CLS_DUAL_IO: begin
        if (cnt == C4)       code = 2'd0;
        else if (cnt == C6)  code = 2'd1;
        else if (cnt == C8)  code = 2'd2;
        else if (cnt == C10) code = 2'd3;
        else                 ok   = 1'b0;
      end
      CLS_QUAD_IO: begin
        if (cnt == C4)       code = 2'd1;
        else if (cnt == C6)  code = 2'd0;
        else if (cnt == C8)  code = 2'd2;
        else if (cnt == C10) code = 2'd3;
        else                 ok   = 1'b0;
      end
      default: ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/fdc_spi_byte.sv
module fdc_spi_byte #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic [7:0] rx,
  output logic       byte_done,
  output logic       active
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

  logic [DW-1:0] div_q;
  logic [2:0]    bit_q;
  logic [7:0]    sh_q;
  logic [7:0]    rx_q;
  logic          act_q;
  logic          sclk_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    done_q <= 1'b0;
    if (rst) begin
      div_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      act_q  <= 1'b0;
      sclk_q <= 1'b0;
    end else if (!act_q) begin
      if (go) begin
        act_q  <= 1'b1;
        sh_q   <= tx;
        div_q  <= '0;
        bit_q  <= '0;
        sclk_q <= 1'b0;
      end
    end else if (div_q == DIV_LAST) begin
      div_q <= '0;
      if (!sclk_q) begin
        sclk_q <= 1'b1;
        rx_q   <= {rx_q[6:0], miso};
      end else begin
        sclk_q <= 1'b0;
        if (bit_q == 3'd7) begin
          act_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          bit_q <= bit_q + 3'd1;
          sh_q  <= {sh_q[6:0], 1'b0};
        end
      end
    end else begin
      div_q <= div_q + DW'(1);
    end
  end

  assign sclk      = sclk_q;
  assign mosi      = sh_q[7];
  assign rx        = rx_q;
  assign byte_done = done_q;
  assign active    = act_q;

  // R9: a new byte is only launched while the shifter is idle
  assert_go_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
    go |-> !act_q);

endmodule

// File: rtl/fdc_ctrl.sv
module fdc_ctrl #(
  parameter int CNT_W    = 4,
  parameter int POLL_MAX = 8,
  parameter int CS_GAP   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [2:0]       op_class,
  input  logic [CNT_W-1:0] dummy_cnt,
  output logic [2:0]       req_cls,
  output logic [CNT_W-1:0] req_cnt,
  input  logic             map_ok,
  input  logic [1:0]       map_code,
  input  logic [CNT_W-1:0] map_cnt,
  output logic             sh_go,
  output logic [7:0]       sh_tx,
  input  logic [7:0]       sh_rx,
  input  logic             sh_done,
  output logic             cs_n,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [CNT_W-1:0] applied_cnt
);
  import fdc_pkg::*;

  localparam int PW = $clog2(POLL_MAX + 1);
  localparam int GW = $clog2(CS_GAP + 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(POLL_MAX - 1);
  localparam logic [GW-1:0] GAP_LAST  = GW'(CS_GAP - 1);

  state_t           state_q;
  phase_t           phase_q;
  logic [2:0]       cls_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] app_q;
  logic [1:0]       code_q;
  logic [7:0]       cfg_q;
  logic [7:0]       st_q;
  logic [7:0]       rx_q;
  logic [1:0]       bidx_q;
  logic [PW-1:0]    poll_q;
  logic [GW-1:0]    gap_q;
  logic [1:0]       len_w;

  assign len_w = phase_len(phase_q);

  always_comb begin
    case (bidx_q)
      2'd0:    sh_tx = phase_opcode(phase_q);
      2'd1:    sh_tx = (phase_q == PH_WRITE) ? st_q : 8'h00;
      default: sh_tx = {code_q, cfg_q[5:0]};
    endcase
  end

  always_ff @(posedge clk) begin
    sh_go <= 1'b0;
    done  <= 1'b0;
    err   <= 1'b0;
    if (rst) begin
      state_q     <= ST_IDLE;
      phase_q     <= PH_CFG_RD1;
      cls_q       <= '0;
      cnt_q       <= '0;
      app_q       <= '0;
      code_q      <= '0;
      cfg_q       <= '0;
      st_q        <= '0;
      rx_q        <= '0;
      bidx_q      <= '0;
      poll_q      <= '0;
      gap_q       <= '0;
      cs_n        <= 1'b1;
      busy        <= 1'b0;
      applied_cnt <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            cls_q   <= op_class;
            cnt_q   <= dummy_cnt;
            busy    <= 1'b1;
            state_q <= ST_MAP;
          end
        end
        ST_MAP: begin
          code_q <= map_code;
          app_q  <= map_cnt;
          if (!map_ok) begin
            done    <= 1'b1;
            err     <= 1'b1;
            busy    <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            phase_q <= PH_CFG_RD1;
            state_q <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          cs_n    <= 1'b0;
          bidx_q  <= '0;
          state_q <= ST_SEND;
        end
        ST_SEND: begin
          sh_go   <= 1'b1;
          state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (sh_done) begin
            rx_q <= sh_rx;
            if (bidx_q == len_w - 2'd1) begin
              cs_n    <= 1'b1;
              gap_q   <= '0;
              state_q <= ST_GAP;
            end else begin
              bidx_q  <= bidx_q + 2'd1;
              state_q <= ST_SEND;
            end
          end
        end
        ST_GAP: begin
          if (gap_q == GAP_LAST) state_q <= ST_NEXT;
          else                   gap_q   <= gap_q + GW'(1);
        end
        ST_NEXT: begin
          state_q <= ST_LOAD;
          case (phase_q)
            PH_CFG_RD1: begin
              cfg_q <= rx_q;
              if (rx_q[7:6] == code_q) begin
                done        <= 1'b1;
                busy        <= 1'b0;
                applied_cnt <= app_q;
                state_q     <= ST_IDLE;
              end else begin
                phase_q <= PH_ST_RD;
              end
            end
            PH_ST_RD: begin
              st_q    <= rx_q;
              phase_q <= PH_WEN;
            end
            PH_WEN: phase_q <= PH_WRITE;
            PH_WRITE: begin
              poll_q  <= '0;
              phase_q <= PH_POLL;
            end
            PH_POLL: begin
              if (!rx_q[0]) begin
                phase_q <= PH_CFG_RD2;
              end else if (poll_q == POLL_LAST) begin
                done    <= 1'b1;
                err     <= 1'b1;
                busy    <= 1'b0;
                state_q <= ST_IDLE;
              end else begin
                poll_q <= poll_q + PW'(1);
              end
            end
            default: begin
              done    <= 1'b1;
              busy    <= 1'b0;
              state_q <= ST_IDLE;
              if (rx_q[7:6] == code_q) applied_cnt <= app_q;
              else                     err         <= 1'b1;
            end
          endcase
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_cls = cls_q;
  assign req_cnt = cnt_q;

  // R10: err only with done
  assert_err_with_done_R10: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

  // R10: done lasts one cycle
  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: applied count moves only on a successful completion
  assert_applied_on_success_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(applied_cnt) |-> (done && !err));

  // R9: chip select is only active during a request
  assert_cs_in_request_R9: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> busy);

  // R3: a rejected request ends at once with no bus activity
  assert_reject_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_MAP && !map_ok) |=> (done && err && cs_n));

endmodule

// File: rtl/flash_dummy_cfg.sv
module flash_dummy_cfg #(
  parameter int CNT_W    = 4,
  parameter int HALF_DIV = 2,
  parameter int POLL_MAX = 8,
  parameter int CS_GAP   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [2:0]       op_class,
  input  logic [CNT_W-1:0] dummy_cnt,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [CNT_W-1:0] applied_cnt,
  output logic             spi_sclk,
  output logic             spi_cs_n,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  logic [2:0]       req_cls;
  logic [CNT_W-1:0] req_cnt;
  logic             map_ok;
  logic [1:0]       map_code;
  logic [CNT_W-1:0] map_cnt;
  logic             sh_go;
  logic [7:0]       sh_tx;
  logic [7:0]       sh_rx;
  logic             sh_done;
  logic             sh_active;

  fdc_code_map #(.CNT_W(CNT_W)) u_map (
    .cls     (req_cls),
    .cnt     (req_cnt),
    .ok      (map_ok),
    .code    (map_code),
    .eff_cnt (map_cnt)
  );

  fdc_spi_byte #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .go        (sh_go),
    .tx        (sh_tx),
    .miso      (spi_miso),
    .sclk      (spi_sclk),
    .mosi      (spi_mosi),
    .rx        (sh_rx),
    .byte_done (sh_done),
    .active    (sh_active)
  );

  fdc_ctrl #(.CNT_W(CNT_W), .POLL_MAX(POLL_MAX), .CS_GAP(CS_GAP)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .op_class    (op_class),
    .dummy_cnt   (dummy_cnt),
    .req_cls     (req_cls),
    .req_cnt     (req_cnt),
    .map_ok      (map_ok),
    .map_code    (map_code),
    .map_cnt     (map_cnt),
    .sh_go       (sh_go),
    .sh_tx       (sh_tx),
    .sh_rx       (sh_rx),
    .sh_done     (sh_done),
    .cs_n        (spi_cs_n),
    .busy        (busy),
    .done        (done),
    .err         (err),
    .applied_cnt (applied_cnt)
  );

  // R9: clock parked low while chip select is released
  assert_sclk_parked_R9: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk);

  // R9: shifter never runs with chip select released
  assert_shift_under_cs_R9: assert property (@(posedge clk) disable iff (rst)
    sh_active |-> !spi_cs_n);

endmodule

// File: tb/flash_dummy_cfg_bench.sv
module flash_dummy_cfg_bench;
  localparam int CW = 4;
  localparam int POLL = 8;
  localparam logic [7:0] SR_BASE = 8'h3C;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [2:0]    op_class = '0;
  logic [CW-1:0] dummy_cnt = '0;
  logic          busy, done, err, sclk, cs_n, mosi;
  logic          miso = 1'b0;
  logic [CW-1:0] applied;

  flash_dummy_cfg #(.CNT_W(CW), .HALF_DIV(2), .POLL_MAX(POLL), .CS_GAP(3)) u_flash_dummy_cfg (
    .clk(clk), .rst(rst), .start(start), .op_class(op_class), .dummy_cnt(dummy_cnt),
    .busy(busy), .done(done), .err(err), .applied_cnt(applied),
    .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso));

  int checks = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural flash
  logic [7:0] fl_cr = 8'h00;
  int         busy_cfg = 0;
  int         busy_left = 0;
  bit         stuck = 0;
  bit         wel = 0;
  logic [7:0] in_sh = '0;
  logic [7:0] resp = '0;
  int         nbits = 0;
  logic [7:0] txn[$];
  int         op_log[$];
  logic [7:0] wr_sr = '0;
  logic [7:0] wr_cr = '0;
  int         n_writes = 0;

  always @(negedge cs_n) begin
    nbits = 0;
    txn.delete();
  end

  always @(posedge sclk) if (!cs_n) begin
    in_sh = {in_sh[6:0], mosi};
    nbits++;
    if (nbits % 8 == 0) begin
      txn.push_back(in_sh);
      if (nbits == 8) begin
        op_log.push_back(int'(in_sh));
        if (in_sh == 8'h15) resp = fl_cr;
        else if (in_sh == 8'h05) begin
          resp = SR_BASE | ((busy_left > 0) ? 8'h01 : 8'h00);
          if (busy_left > 0) busy_left--;
        end else resp = 8'h00;
      end
    end
  end

  always @(negedge sclk) if (!cs_n && nbits >= 8)
    miso = resp[7 - ((nbits - 8) % 8)];

  always @(posedge cs_n) begin
    if (txn.size() == 1 && txn[0] == 8'h06) wel = 1;
    if (txn.size() == 3 && txn[0] == 8'h01 && wel) begin
      wr_sr = txn[1];
      wr_cr = txn[2];
      n_writes++;
      if (!stuck) fl_cr = txn[2];
      busy_left = busy_cfg;
      wel = 0;
    end
  end

  // per-clock reference comparison
  logic [CW-1:0] exp_applied = '0;
  int proto_err = 0;
  int app_err = 0;
  always @(negedge clk) if (!rst) begin
    if (cs_n && sclk) proto_err++;
    if (!done && applied !== exp_applied) app_err++;
    if (err && !done) app_err++;
  end

  function automatic void ref_map(input int c, input int n, output bit ok, output int code, output int eff);
    ok = 1; code = 0; eff = n;
    case (c)
      0: eff = 0;
      1: if (n == 6) code = 1; else if (n == 8) code = 0; else if (n == 10) code = 3; else ok = 0;
      2: if (n == 4) code = 0; else if (n == 6) code = 1; else if (n == 8) code = 2;
         else if (n == 10) code = 3; else ok = 0;
      3: if (n == 4) code = 1; else if (n == 6) code = 0; else if (n == 8) code = 2;
         else if (n == 10) code = 3; else ok = 0;
      default: ok = 0;
    endcase
  endfunction

  bit hung = 0;

  task automatic run(input int c, input int n, input bit poke);
    bit ok; int code; int eff; int exq[$]; bit exp_err; bit wrote; int polls; int w;
    logic [7:0] old;
    string tag;
    ref_map(c, n, ok, code, eff);
    tag = !ok ? "R3" : (c == 0) ? "R2" : "R1";
    old = fl_cr;
    op_log.delete();
    n_writes = 0;
    exp_err = !ok;
    wrote = 0;
    if (ok) begin
      exq.push_back(8'h15);
      if (old[7:6] != code[1:0]) begin
        wrote = 1;
        exq.push_back(8'h05); exq.push_back(8'h06); exq.push_back(8'h01);
        polls = (busy_cfg >= POLL) ? POLL : busy_cfg + 1;
        for (int i = 0; i < polls; i++) exq.push_back(8'h05);
        if (busy_cfg >= POLL) exp_err = 1;
        else begin
          exq.push_back(8'h15);
          if (stuck) exp_err = 1;
        end
      end
    end
    @(negedge clk);
    op_class = 3'(c); dummy_cnt = CW'(n); start = 1;
    @(negedge clk);
    start = 0;
    w = 0;
    while (done !== 1'b1 && w < 20000) begin
      @(negedge clk);
      w++;
      if (poke && w == 30) begin
        chk(busy === 1'b1, "R10", "busy during request", int'(busy), 1);
        op_class = 3'd7; dummy_cnt = '0; start = 1;
      end else start = 0;
    end
    if (w >= 20000) begin
      hung = 1;
      chk(0, "R10", "done never seen", 0, 1);
      return;
    end
    if (!exp_err) exp_applied = CW'(eff);
    chk(err === exp_err, tag, "err", int'(err), int'(exp_err));
    chk(applied === exp_applied, "R8", "applied_cnt", int'(applied), int'(exp_applied));
    begin
      bit same = (op_log.size() == exq.size());
      if (same) foreach (exq[i]) if (op_log[i] != exq[i]) same = 0;
      chk(same, wrote ? "R5" : "R4", "command sequence length", op_log.size(), exq.size());
    end
    if (wrote) begin
      chk(wr_sr === SR_BASE, "R5", "status byte written", int'(wr_sr), int'(SR_BASE));
      chk(wr_cr === {code[1:0], old[5:0]}, "R5", "config byte written", int'(wr_cr), int'({code[1:0], old[5:0]}));
    end
    @(negedge clk);
    chk(done === 1'b0, "R10", "done pulse width", int'(done), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    int vals[6] = '{0, 4, 6, 7, 8, 10};
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(busy === 0 && done === 0 && err === 0, "R10", "reset flags", int'({busy, done, err}), 0);
    chk(cs_n === 1 && sclk === 0, "R9", "reset bus idle", int'({cs_n, sclk}), 2);
    chk(applied === 0, "R8", "reset applied", int'(applied), 0);

    // R4: field already matches -> single read only
    fl_cr = 8'h25; busy_cfg = 2;
    run(1, 8, 0);
    // R5/R6: rewrite with polling
    fl_cr = 8'h05; busy_cfg = 3;
    run(1, 6, 0);
    chk(fl_cr === 8'h45, "R5", "flash config after write", int'(fl_cr), 8'h45);
    // sweep of classes and counts (R1, R2, R3)
    for (int c = 0; c < 5; c++)
      for (int k = 0; k < 6; k++) begin
        if (hung) break;
        fl_cr = 8'h5A ^ 8'(c * 37 + vals[k] * 11);
        busy_cfg = (c + k) % 3;
        run(c, vals[k], 0);
      end
    // R6: busy timeout
    fl_cr = 8'h00; busy_cfg = 20;
    run(3, 8, 0);
    busy_left = 0;
    // R7: register does not take the write
    stuck = 1; fl_cr = 8'h81; busy_cfg = 1;
    run(2, 4, 0);
    chk(applied === exp_applied, "R7", "applied kept after verify error", int'(applied), int'(exp_applied));
    stuck = 0;
    // R2: plain class with nonzero field
    fl_cr = 8'hC3; busy_cfg = 0;
    run(0, 9, 0);
    chk(applied === 0, "R2", "plain applied count", int'(applied), 0);
    // R10: start while busy is ignored
    fl_cr = 8'h00; busy_cfg = 1;
    run(3, 10, 1);
    begin
      int extra = 0;
      repeat (200) begin @(negedge clk); if (done) extra++; end
      chk(extra == 0, "R10", "extra completion from ignored start", extra, 0);
    end
    chk(proto_err == 0, "R9", "clock high with chip select released", proto_err, 0);
    chk(app_err == 0, "R8", "per-clock applied/err mismatches", app_err, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule